// File: doc/BRIEF.md
# SDIO Single-Byte Register Access Unit

This unit executes one single-byte register access of an SDIO card per command. It takes a decoded command made of a direction flag, a read-after-write flag, a 3-bit function number, a 17-bit register address and a data byte. It checks the function against the set of implemented functions. For an implemented function it issues one strobe on a simple register bus, and the register bus returns a byte one cycle after the strobe. The unit then assembles the response payload: the result byte plus status flags.

The payload has two layouts, chosen by the bus mode sampled with the command. The long layout is the content of a 48-bit SD-mode response without its CRC and end bit. The short layout is the 16-bit SPI-mode response. A write that sets the reset bit of the function-0 reset register does not store that bit. Instead it raises a one-cycle I/O reset pulse.

A small controller runs four states:
- `ST_IDLE`: waits for a command.
- `ST_STROBE`: drives the bus strobe.
- `ST_WAIT`: captures the returned byte.
- `ST_REPLY`: presents the response for one cycle.

The transitions are:
- IDLE→STROBE on an accepted command to an implemented function.
- IDLE→REPLY on an accepted command to an unimplemented function.
- STROBE→WAIT, always.
- WAIT→REPLY, always.
- REPLY→IDLE, always.

Top module: `sdio_direct_access`

## Requirements
- R1: After reset, `busy`, `bus_stb`, `io_reset` and `rsp_valid` are all low.
- R2: A read (`cmd_write`=0) to an implemented function issues one strobe with `bus_we`=0 and the command's function and address. The response byte is the `bus_rdata` value returned in the cycle after the strobe.
- R3: A write with `cmd_raw`=0 issues one strobe with `bus_we`=1 and carries the command byte on `bus_wdata`. The response byte equals the command byte, whatever the bus returns.
- R4: A write with `cmd_raw`=1 returns as its response byte the value the bus returns in the cycle after the strobe. This value may differ from the byte written.
- R5: `bus_stb` is high for exactly one cycle per command, in the cycle after the command is accepted. `rsp_valid` is high for one cycle, three cycles after acceptance.
- R6: A command to a function whose bit in `FUNC_MASK` is 0 produces no strobe. Its response comes one cycle after acceptance, with a zero response byte and the out-of-range flag set.
- R7: With `cmd_spi`=0, `rsp_payload` is {2'b00, the 6-bit index 52, 16'h0000, flags, byte}. The flags byte has bits [5:4]=2'b01, bit 1 as the out-of-range flag, and all other bits zero.
- R8: With `cmd_spi`=1, `rsp_payload` is {24'h0, flags, byte}. The flags byte has bit 4 as the out-of-range flag and all other bits zero.
- R9: A write to function 0, address 6, with data bit 3 set raises `io_reset` in the strobe cycle and clears bit 3 on `bus_wdata`. Any other write raises no pulse.
- R10: While `busy` is high, `cmd_valid` is ignored. No extra strobe or response follows, and the command in progress keeps its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present (accepted when not busy) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_raw | input | 1 | Read-after-write request |
| cmd_func | input | 3 | Function number |
| cmd_addr | input | 17 | Register address |
| cmd_wdata | input | 8 | Write byte |
| cmd_spi | input | 1 | 1 = short SPI layout, 0 = long SD layout |
| busy | output | 1 | Command in progress |
| bus_stb | output | 1 | Register bus strobe |
| bus_we | output | 1 | Register bus write enable |
| bus_func | output | 3 | Register bus function |
| bus_addr | output | 17 | Register bus address |
| bus_wdata | output | 8 | Register bus write byte |
| bus_rdata | input | 8 | Register bus return byte, valid one cycle after strobe |
| io_reset | output | 1 | One-cycle I/O reset pulse |
| rsp_valid | output | 1 | Response payload valid |
| rsp_payload | output | 40 | Response payload |

## Verification
Reads use several functions and addresses. The bench's register model returns a byte derived from the address, and a byte different from the written one after a write. This separates the plain echo of a write without read-after-write from a real bus return. Commands to unmasked functions are sent in both layouts; they must show the flag with no strobe and the shorter latency.

Writes to the reset register are sent with bit 3 set, with bit 3 clear, and to the same address of another function. Only the first must pulse. A command held on `cmd_valid` while its fields change shows whether a busy command is ignored.

// File: rtl/sdio_dra_pkg.sv
package sdio_dra_pkg;
    parameter int FUNC_W = 3;
    parameter int ADDR_W = 17;
    parameter int DATA_W = 8;
    parameter int IDX_W  = 6;
    localparam int PAYLOAD_W = 2 + IDX_W + 16 + 2 * DATA_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_REPLY  = 2'd3
    } dra_state_e;

    typedef struct packed {
        logic              write;
        logic              raw;
        logic [FUNC_W-1:0] func;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              spi;
    } dra_cmd_t;
endpackage

// File: rtl/sdio_dra_decode.sv
module sdio_dra_decode
    import sdio_dra_pkg::*;
#(
    parameter logic [(1<<FUNC_W)-1:0] FUNC_MASK  = 8'b0000_0111,
    parameter logic [ADDR_W-1:0]      RESET_ADDR = 17'd6,
    parameter int                     RESET_BIT  = 3
) (
    input  dra_cmd_t          cmd,
    output logic              out_of_range,
    output logic              reset_hit,
    output logic [DATA_W-1:0] wdata_eff
);
    localparam logic [DATA_W-1:0] RESET_MASK = DATA_W'(1) << RESET_BIT;

    always_comb begin
        out_of_range = !FUNC_MASK[cmd.func];
        reset_hit    = cmd.write && (cmd.func == '0) &&
                       (cmd.addr == RESET_ADDR) && cmd.wdata[RESET_BIT];
        wdata_eff    = reset_hit ? (cmd.wdata & ~RESET_MASK) : cmd.wdata;
    end
endmodule

// File: rtl/sdio_dra_ctrl.sv
module sdio_dra_ctrl
    import sdio_dra_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  dra_cmd_t          cmd_in,
    input  logic              dec_range,
    input  logic              dec_reset,
    input  logic [DATA_W-1:0] dec_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              bus_stb,
    output logic              io_reset,
    output logic              rsp_valid,
    output dra_cmd_t          cmd_q,
    output logic              range_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] data_q
);
    dra_state_e state, nxt;
    logic       reset_q;
    logic       accept;

    assign accept = (state == ST_IDLE) && cmd_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cmd_valid) nxt = dec_range ? ST_REPLY : ST_STROBE;
            ST_STROBE: nxt = ST_WAIT;
            ST_WAIT:   nxt = ST_REPLY;
            ST_REPLY:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            range_q <= 1'b0;
            reset_q <= 1'b0;
            wdata_q <= '0;
            data_q  <= '0;
        end else begin
            if (accept) begin
                cmd_q   <= cmd_in;
                range_q <= dec_range;
                reset_q <= dec_reset && !dec_range;
                wdata_q <= dec_wdata;
                if (dec_range) data_q <= '0;
            end
            if (state == ST_WAIT)
                data_q <= (cmd_q.write && !cmd_q.raw) ? cmd_q.wdata : bus_rdata;
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        bus_stb   = (state == ST_STROBE);
        io_reset  = (state == ST_STROBE) && reset_q;
        rsp_valid = (state == ST_REPLY);
    end

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |=> !bus_stb);
    a_r5_reply_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !range_q) |-> $past(bus_stb, 2));
    a_r6_range_fast_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_range) |=> (rsp_valid && !bus_stb));
    a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rsp_valid) |=> $stable(cmd_q));
    a_r1_idle_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sdio_dra_format.sv
module sdio_dra_format
    import sdio_dra_pkg::*;
#(
    parameter logic [IDX_W-1:0] CMD_INDEX = 6'd52
) (
    input  logic                 spi,
    input  logic                 range,
    input  logic [DATA_W-1:0]    data,
    output logic [PAYLOAD_W-1:0] payload
);
    logic [7:0] sd_flags;
    logic [7:0] spi_flags;

    always_comb begin
        sd_flags  = {2'b00, 2'b01, 2'b00, range, 1'b0};
        spi_flags = {3'b000, range, 4'b0000};
        if (spi)
            payload = {{(PAYLOAD_W - 8 - DATA_W){1'b0}}, spi_flags, data};
        else
            payload = {2'b00, CMD_INDEX, 16'h0000, sd_flags, data};
    end
endmodule

// File: rtl/sdio_direct_access.sv
module sdio_direct_access
    import sdio_dra_pkg::*;
#(
    parameter logic [(1<<FUNC_W)-1:0] FUNC_MASK  = 8'b0000_0111,
    parameter logic [ADDR_W-1:0]      RESET_ADDR = 17'd6,
    parameter int                     RESET_BIT  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_write,
    input  logic                 cmd_raw,
    input  logic [FUNC_W-1:0]    cmd_func,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [DATA_W-1:0]    cmd_wdata,
    input  logic                 cmd_spi,
    output logic                 busy,
    output logic                 bus_stb,
    output logic                 bus_we,
    output logic [FUNC_W-1:0]    bus_func,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    bus_wdata,
    input  logic [DATA_W-1:0]    bus_rdata,
    output logic                 io_reset,
    output logic                 rsp_valid,
    output logic [PAYLOAD_W-1:0] rsp_payload
);
    dra_cmd_t          cmd_in, cmd_q;
    logic              dec_range, dec_reset, range_q;
    logic [DATA_W-1:0] dec_wdata, wdata_q, data_q;

    assign cmd_in = '{write: cmd_write, raw: cmd_raw, func: cmd_func,
                      addr: cmd_addr, wdata: cmd_wdata, spi: cmd_spi};

    sdio_dra_decode #(
        .FUNC_MASK (FUNC_MASK),
        .RESET_ADDR(RESET_ADDR),
        .RESET_BIT (RESET_BIT)
    ) u_decode (
        .cmd         (cmd_in),
        .out_of_range(dec_range),
        .reset_hit   (dec_reset),
        .wdata_eff   (dec_wdata)
    );

    sdio_dra_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_in   (cmd_in),
        .dec_range(dec_range),
        .dec_reset(dec_reset),
        .dec_wdata(dec_wdata),
        .bus_rdata(bus_rdata),
        .busy     (busy),
        .bus_stb  (bus_stb),
        .io_reset (io_reset),
        .rsp_valid(rsp_valid),
        .cmd_q    (cmd_q),
        .range_q  (range_q),
        .wdata_q  (wdata_q),
        .data_q   (data_q)
    );

    sdio_dra_format u_format (
        .spi    (cmd_q.spi),
        .range  (range_q),
        .data   (data_q),
        .payload(rsp_payload)
    );

    always_comb begin
        bus_we    = bus_stb && cmd_q.write;
        bus_func  = cmd_q.func;
        bus_addr  = cmd_q.addr;
        bus_wdata = wdata_q;
    end

    a_r9_reset_target: assert property (@(posedge clk) disable iff (!rst_n)
        io_reset |-> (bus_stb && bus_we && bus_func == '0 &&
                      bus_addr == RESET_ADDR && !bus_wdata[RESET_BIT]));
    a_r6_masked_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |-> FUNC_MASK[bus_func]);
    a_r3_echo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cmd_q.write && !cmd_q.raw && !range_q) |->
        (rsp_payload[DATA_W-1:0] == cmd_q.wdata));
endmodule

// File: tb/test_sdio_direct_access.sv
module test_sdio_direct_access;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_raw = 1'b0, cmd_spi = 1'b0;
    logic [2:0]  cmd_func = '0;
    logic [16:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        busy, bus_stb, bus_we, io_reset, rsp_valid;
    logic [2:0]  bus_func;
    logic [16:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = '0;
    logic [39:0] rsp_payload;

    int tests = 0, fails = 0;
    int stb_count = 0, rst_count = 0;
    logic [39:0] exp_q[$];
    logic [28:0] bus_q[$];   // {we, func, addr, wdata}

    always #5 clk = ~clk;

    sdio_direct_access i_sdio_direct_access (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_raw(cmd_raw), .cmd_func(cmd_func), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_spi(cmd_spi), .busy(busy), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_func(bus_func), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .io_reset(io_reset),
        .rsp_valid(rsp_valid), .rsp_payload(rsp_payload)
    );

    // register model: reads return address-derived byte, writes return altered byte
    always @(posedge clk)
        if (bus_stb)
            bus_rdata <= bus_we ? (bus_wdata ^ 8'h5A) : (bus_addr[7:0] ^ {bus_func, 5'b0});

    task automatic check(input bit ok, input string req, input logic [39:0] act,
                         input logic [39:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] pl(input bit spi, input bit rng, input logic [7:0] d);
        if (spi) return {24'h0, 3'b000, rng, 4'b0000, d};
        return {2'b00, 6'd52, 16'h0000, 2'b00, 2'b01, 2'b00, rng, 1'b0, d};
    endfunction

    // monitor: bus strobes, reset pulses, responses
    always @(negedge clk) begin
        if (rst_n && bus_stb) begin
            logic [28:0] e;
            stb_count++;
            e = (bus_q.size() > 0) ? bus_q.pop_front() : '1;
            check({bus_we, bus_func, bus_addr, bus_wdata} == e, "R2/R3 bus fields",
                  40'({bus_we, bus_func, bus_addr, bus_wdata}), 40'(e));
        end
        if (rst_n && io_reset) rst_count++;
        if (rst_n && rsp_valid) begin
            logic [39:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
            check(rsp_payload == e, "R2/R3/R4/R7/R8 payload", rsp_payload, e);
        end
    end

    task automatic send(input bit w, input bit raw, input logic [2:0] f,
                        input logic [16:0] a, input logic [7:0] d, input bit spi,
                        input int hold, input string req);
        bit rng, rh;
        logic [7:0] wd, exp_d;
        int k, s0, r0;
        rng = !(f <= 3'd2);
        rh  = w && f == 0 && a == 17'd6 && d[3];
        wd  = rh ? (d & 8'hF7) : d;
        if (rng) exp_d = 8'h00;
        else if (w && !raw) exp_d = d;
        else if (w) exp_d = wd ^ 8'h5A;
        else exp_d = a[7:0] ^ {f, 5'b0};
        exp_q.push_back(pl(spi, rng, exp_d));
        if (!rng) bus_q.push_back({w, f, a, wd});
        s0 = stb_count; r0 = rst_count;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = w; cmd_raw = raw; cmd_func = f;
        cmd_addr = a; cmd_wdata = d; cmd_spi = spi;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k <= hold) begin
                cmd_addr = cmd_addr + 17'd3; cmd_wdata = ~cmd_wdata; cmd_spi = ~cmd_spi;
            end else cmd_valid = 1'b0;
        end while (!rsp_valid && k < 20);
        cmd_valid = 1'b0;
        check(k == (rng ? 1 : 3), {req, " R5/R6 latency"}, 40'(k), 40'(rng ? 1 : 3));
        @(negedge clk);
        check(stb_count - s0 == (rng ? 0 : 1), {req, " R5/R6/R10 strobe count"},
              40'(stb_count - s0), 40'(rng ? 0 : 1));
        check(rst_count - r0 == (rh ? 1 : 0), {req, " R9 reset pulse"},
              40'(rst_count - r0), 40'(rh ? 1 : 0));
        check(!busy && !rsp_valid, {req, " R10 idle after reply"}, 40'(busy), 40'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !bus_stb && !io_reset && !rsp_valid, "R1 reset",
              40'({busy, bus_stb, io_reset, rsp_valid}), 40'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !bus_stb && !io_reset && !rsp_valid, "R1 after release",
              40'({busy, bus_stb, io_reset, rsp_valid}), 40'(0));
        send(0, 0, 3'd1, 17'h12345, 8'h00, 0, 0, "R2 read SD R7");
        send(0, 0, 3'd2, 17'h000FF, 8'h00, 1, 0, "R2 read SPI R8");
        send(0, 1, 3'd0, 17'h1FFFF, 8'h11, 0, 0, "R2 read raw ignored");
        send(1, 0, 3'd1, 17'h00010, 8'hA7, 0, 0, "R3 write echo");
        send(1, 0, 3'd2, 17'h0ABCD, 8'h3C, 1, 0, "R3 write echo SPI");
        send(1, 1, 3'd2, 17'h00020, 8'h3C, 0, 0, "R4 read-after-write");
        send(1, 1, 3'd1, 17'h10000, 8'hFF, 1, 0, "R4 read-after-write SPI");
        send(0, 0, 3'd5, 17'h00001, 8'h00, 0, 0, "R6 unmasked SD");
        send(1, 1, 3'd7, 17'h00006, 8'h08, 1, 0, "R6 unmasked SPI");
        send(1, 1, 3'd0, 17'h00006, 8'h0F, 0, 0, "R9 reset bit");
        send(1, 0, 3'd0, 17'h00006, 8'h08, 1, 0, "R9 reset bit echo");
        send(1, 0, 3'd0, 17'h00006, 8'h07, 0, 0, "R9 no reset bit");
        send(1, 0, 3'd1, 17'h00006, 8'h08, 0, 0, "R9 other function");
        send(1, 0, 3'd0, 17'h00007, 8'h08, 0, 0, "R9 other address");
        send(0, 0, 3'd1, 17'h00042, 8'h00, 0, 2, "R10 held while busy");
        send(1, 1, 3'd2, 17'h00043, 8'h90, 1, 2, "R10 held write");
        check(exp_q.size() == 0 && bus_q.size() == 0, "R2/R5 all responses seen",
              40'(exp_q.size() + bus_q.size()), 40'(0));
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule